// File: doc/BRIEF.md
# Two-Port Byte Memory with Mailbox Interrupts

This block is a 1024 x 8 memory shared by two independent synchronous ports, called left and right. Each port has an active-low select, an active-low output enable, a read/write strobe (high reads, low writes), a 10-bit address, write data, registered read data and a read-valid flag. Either port can read or write any byte at any time. A tristate data bus is replaced here by read data that is forced to zero whenever the port is not reading.

The two highest addresses double as mailboxes. A write by the right port to 0x3FE pulls the left port's active-low interrupt low. A write by the left port to 0x3FF does the same for the right port's interrupt. The owning port clears its interrupt by touching its mailbox with select and output enable low, whether it reads or writes. The message bytes themselves are ordinary memory.

Each port also takes an inhibit input from an external arbiter. An inhibited write stores nothing and raises no interrupt. Typical use has one processor on each port: it drops a message in the other side's mailbox and gets an interrupt back once the reply has been posted.

Top module: `dpr_mailbox_ram`

## Requirements
- R1: A write happens at a clock edge when the port has select low, strobe low and inhibit low; the byte at that address then holds the write data for later reads by either port.
- R2: With select low, output enable low and strobe high, the port's read data holds the byte at the address one cycle later and read-valid is 1; in every other case, one cycle later, read-valid is 0 and read data is 0.
- R3: A read returns the byte as it stood before any write made at the same clock edge.
- R4: With select high a port is idle: no read, no write, no interrupt set, no interrupt clear, whatever its other inputs are.
- R5: A right-port write to 0x3FE drives the left interrupt low from the next cycle onward.
- R6: The left interrupt returns high one cycle after the left port has select and output enable low at address 0x3FE; the strobe level does not matter.
- R7: The right interrupt goes low one cycle after a left-port write to 0x3FF, and returns high one cycle after the right port has select and output enable low at 0x3FF.
- R8: An inhibited write changes neither the memory nor any interrupt; inhibit does not block reads or interrupt clears.
- R9: When a set and a clear for the same interrupt happen at the same edge, the interrupt ends up low.
- R10: When both ports write the same address at the same edge without inhibit, the left port's data is stored.
- R11: Reset (synchronous, active low) sets both interrupts high, read-valid to 0 and read data to 0, and leaves the memory contents unchanged. No access takes effect while reset is low.
- R12: Both mailbox bytes can be read and written by both ports like any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| l_ce_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left strobe: 1 read, 0 write |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_inhibit | input | 1 | Left write inhibit from the arbiter |
| l_rdata | output | 8 | Left read data, zero when not reading |
| l_rvalid | output | 1 | Left read data valid |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right strobe: 1 read, 0 write |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_inhibit | input | 1 | Right write inhibit from the arbiter |
| r_rdata | output | 8 | Right read data, zero when not reading |
| r_rvalid | output | 1 | Right read data valid |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The hardest cases to reach are the ones where both ports act on the same mailbox at the same edge: a set meeting a clear, or a read meeting a write to the same byte. Uniform random addresses would almost never produce them. The stimulus therefore draws most addresses from the two mailboxes and a small pool of low addresses, and adds directed cycles that line up set against clear, read against write, and two equal-address writes. Inhibit is applied at random, so inhibited mailbox writes also hit pending and idle flags.

// File: rtl/dpr_pkg.sv
`timescale 1ns/100ps
// Shared types for the two-port mailbox memory.
// Assumes: port index 0 is the left port and index 1 is the right port.
package dpr_pkg;

    localparam int NPORT  = 2;
    localparam int P_LEFT  = 0;
    localparam int P_RIGHT = 1;

    // Decoded per-port operation for one clock edge.
    typedef struct packed {
        logic read_en;   // data is returned next cycle
        logic write_en;  // byte is stored at this edge
        logic peek_en;   // select and output enable low: a mailbox clear qualifier
    } port_cmd_t;

endpackage

// File: rtl/dpr_port_decode.sv
`timescale 1ns/100ps
// Turns one port's active-low controls into read, write and peek enables.
// Assumes: inhibit only gates writes; during reset nothing is enabled.
module dpr_port_decode (
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              inhibit,
    output dpr_pkg::port_cmd_t cmd
);

    logic selected;

    // Port is active only when selected and out of reset.
    always_comb selected = rst_n && !ce_n;

    // Enable decode for this port.
    always_comb begin
        cmd.write_en = selected && !we_n && !inhibit;
        cmd.read_en  = selected && !oe_n && we_n;
        cmd.peek_en  = selected && !oe_n;
    end

endmodule

// File: rtl/dpr_mem_array.sv
`timescale 1ns/100ps
// Byte array with NPORT synchronous write ports and registered read ports.
// Assumes: reads return the contents from before the current edge's writes;
// on equal write addresses the lowest port index is stored. Array is not reset.
module dpr_mem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int NPORT  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              wr_en,
    input  logic [NPORT-1:0]              rd_en,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
    input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
    output logic [NPORT-1:0][DATA_W-1:0]  rdata,
    output logic [NPORT-1:0]              rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Writes, highest index first so that port 0 takes precedence.
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (wr_en[p]) begin
                mem[addr[p]] <= wdata[p];
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        // Registered read with zeroed data when idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[p]  <= '0;
                rvalid[p] <= 1'b0;
            end else begin
                rvalid[p] <= rd_en[p];
                rdata[p]  <= rd_en[p] ? mem[addr[p]] : '0;
            end
        end
    end

endmodule

// File: rtl/dpr_mbox_flag.sv
`timescale 1ns/100ps
// One active-low mailbox interrupt.
// Assumes: set has priority over clear at the same edge.
module dpr_mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    // Flag register: reset inactive, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else if (set) begin
            irq_n <= 1'b0;
        end else if (clr) begin
            irq_n <= 1'b1;
        end
    end

endmodule

// File: rtl/dpr_mailbox_ram.sv
`timescale 1ns/100ps
// Two-port byte memory whose two top addresses serve as mailboxes.
// The right port writing DEPTH-2 interrupts the left port; the left port
// writing DEPTH-1 interrupts the right port. Each owner clears its interrupt
// by selecting its mailbox with output enable low.
// Assumes: inhibit comes from an external arbiter and blocks writes only.
module dpr_mailbox_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_inhibit,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_irq_n,
    input  logic              r_ce_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_inhibit,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_irq_n
);

    import dpr_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    // Mailbox owned by port p is at DEPTH-2+p.
    localparam logic [ADDR_W-1:0] MBOX_BASE = ADDR_W'(DEPTH - 2);

    logic [NPORT-1:0]             ce_n_v, oe_n_v, we_n_v, inh_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0][DATA_W-1:0] wdata_v, rdata_v;
    logic [NPORT-1:0]             wr_v, rd_v, rvalid_v, irq_n_v;
    port_cmd_t [NPORT-1:0]        cmd;

    // Gather port pins into indexed vectors.
    always_comb begin
        ce_n_v  = {r_ce_n, l_ce_n};
        oe_n_v  = {r_oe_n, l_oe_n};
        we_n_v  = {r_we_n, l_we_n};
        inh_v   = {r_inhibit, l_inhibit};
        addr_v  = {r_addr, l_addr};
        wdata_v = {r_wdata, l_wdata};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int OTHER = NPORT - 1 - p;
        localparam logic [ADDR_W-1:0] MBOX = MBOX_BASE + ADDR_W'(p);

        logic set_hit, clr_hit;

        dpr_port_decode u_dec (
            .rst_n   (rst_n),
            .ce_n    (ce_n_v[p]),
            .oe_n    (oe_n_v[p]),
            .we_n    (we_n_v[p]),
            .inhibit (inh_v[p]),
            .cmd     (cmd[p])
        );

        // Split the decoded command into array enables.
        always_comb begin
            wr_v[p] = cmd[p].write_en;
            rd_v[p] = cmd[p].read_en;
        end

        // Mailbox hits: the other port posts, this port collects.
        always_comb begin
            set_hit = cmd[OTHER].write_en && (addr_v[OTHER] == MBOX);
            clr_hit = cmd[p].peek_en && (addr_v[p] == MBOX);
        end

        dpr_mbox_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_hit),
            .clr   (clr_hit),
            .irq_n (irq_n_v[p])
        );
    end

    dpr_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NPORT  (NPORT)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_v),
        .rd_en  (rd_v),
        .addr   (addr_v),
        .wdata  (wdata_v),
        .rdata  (rdata_v),
        .rvalid (rvalid_v)
    );

    // Fan results back out to the port pins.
    always_comb begin
        l_rdata  = rdata_v[P_LEFT];
        r_rdata  = rdata_v[P_RIGHT];
        l_rvalid = rvalid_v[P_LEFT];
        r_rvalid = rvalid_v[P_RIGHT];
        l_irq_n  = irq_n_v[P_LEFT];
        r_irq_n  = irq_n_v[P_RIGHT];
    end

endmodule

// File: rtl/dpr_mailbox_ram_chk.sv
`timescale 1ns/100ps
// Port-level properties of the mailbox memory, bound to the top module.
module dpr_mailbox_ram_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_ce_n,
    input logic              l_oe_n,
    input logic              l_we_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_inhibit,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_rvalid,
    input logic              l_irq_n,
    input logic              r_ce_n,
    input logic              r_oe_n,
    input logic              r_we_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_inhibit,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_rvalid,
    input logic              r_irq_n
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] MB_L = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] MB_R = ADDR_W'(DEPTH - 1);

    logic post_l, post_r, take_l, take_r;
    always_comb begin
        post_l = !r_ce_n && !r_we_n && !r_inhibit && (r_addr == MB_L);
        post_r = !l_ce_n && !l_we_n && !l_inhibit && (l_addr == MB_R);
        take_l = !l_ce_n && !l_oe_n && (l_addr == MB_L);
        take_r = !r_ce_n && !r_oe_n && (r_addr == MB_R);
    end

    a_r5_left_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        post_l |=> !l_irq_n);
    a_r6_left_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (take_l && !post_l) |=> l_irq_n);
    a_r7_right_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        post_r |=> !r_irq_n);
    a_r7_right_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (take_r && !post_r) |=> r_irq_n);
    a_r8_left_irq_needs_post: assert property (@(posedge clk) disable iff (!rst_n)
        (l_irq_n && !post_l) |=> l_irq_n);
    a_r8_right_irq_needs_post: assert property (@(posedge clk) disable iff (!rst_n)
        (r_irq_n && !post_r) |=> r_irq_n);
    a_r2_left_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && !l_oe_n && l_we_n) |=> l_rvalid);
    a_r2_right_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ce_n && !r_oe_n && r_we_n) |=> r_rvalid);
    a_r4_left_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        l_ce_n |=> (!l_rvalid && l_rdata == '0));
    a_r4_right_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        r_ce_n |=> (!r_rvalid && r_rdata == '0));

endmodule

bind dpr_mailbox_ram dpr_mailbox_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dpr_mailbox_ram.sv
`timescale 1ns/100ps
module tb_dpr_mailbox_ram;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       l_ce_n, l_oe_n, l_we_n, l_inhibit;
    logic [9:0] l_addr;
    logic [7:0] l_wdata;
    logic [7:0] l_rdata;
    logic       l_rvalid, l_irq_n;
    logic       r_ce_n, r_oe_n, r_we_n, r_inhibit;
    logic [9:0] r_addr;
    logic [7:0] r_wdata;
    logic [7:0] r_rdata;
    logic       r_rvalid, r_irq_n;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R11";

    // Reference model state
    logic [7:0] m_mem [1024];
    logic [7:0] e_l_rdata, e_r_rdata;
    logic       e_l_rvalid, e_r_rvalid, e_l_irq, e_r_irq;

    always #2.5 clk = ~clk;

    dpr_mailbox_ram dut (.*);

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] seedval(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // Predict the outputs after the coming edge from the current inputs.
    task automatic predict();
        logic lwr, rwr, lrd, rrd, set_l, set_r, clr_l, clr_r;
        if (!rst_n) begin
            e_l_rdata = 0; e_r_rdata = 0; e_l_rvalid = 0; e_r_rvalid = 0;
            e_l_irq = 1; e_r_irq = 1;
            return;
        end
        lwr = !l_ce_n && !l_we_n && !l_inhibit;
        rwr = !r_ce_n && !r_we_n && !r_inhibit;
        lrd = !l_ce_n && !l_oe_n && l_we_n;
        rrd = !r_ce_n && !r_oe_n && r_we_n;
        e_l_rvalid = lrd; e_l_rdata = lrd ? m_mem[l_addr] : 8'h00;
        e_r_rvalid = rrd; e_r_rdata = rrd ? m_mem[r_addr] : 8'h00;
        set_l = rwr && r_addr == 10'h3FE;
        set_r = lwr && l_addr == 10'h3FF;
        clr_l = !l_ce_n && !l_oe_n && l_addr == 10'h3FE;
        clr_r = !r_ce_n && !r_oe_n && r_addr == 10'h3FF;
        e_l_irq = set_l ? 1'b0 : (clr_l ? 1'b1 : e_l_irq);
        e_r_irq = set_r ? 1'b0 : (clr_r ? 1'b1 : e_r_irq);
        if (rwr) m_mem[r_addr] = r_wdata;
        if (lwr) m_mem[l_addr] = l_wdata;
    endtask

    // One clock: predict, wait to the falling edge, compare all outputs.
    task automatic tick();
        predict();
        @(negedge clk);
        chk("l_rdata", 32'(l_rdata), 32'(e_l_rdata));
        chk("l_rvalid", 32'(l_rvalid), 32'(e_l_rvalid));
        chk("r_rdata", 32'(r_rdata), 32'(e_r_rdata));
        chk("r_rvalid", 32'(r_rvalid), 32'(e_r_rvalid));
        chk("l_irq_n", 32'(l_irq_n), 32'(e_l_irq));
        chk("r_irq_n", 32'(r_irq_n), 32'(e_r_irq));
    endtask

    task automatic lport(bit ce, bit oe, bit we, logic [9:0] a, logic [7:0] d, bit inh);
        l_ce_n = ce; l_oe_n = oe; l_we_n = we; l_addr = a; l_wdata = d; l_inhibit = inh;
    endtask

    task automatic rport(bit ce, bit oe, bit we, logic [9:0] a, logic [7:0] d, bit inh);
        r_ce_n = ce; r_oe_n = oe; r_we_n = we; r_addr = a; r_wdata = d; r_inhibit = inh;
    endtask

    task automatic idle();
        lport(1, 1, 1, 10'h0, 8'h0, 0);
        rport(1, 1, 1, 10'h0, 8'h0, 0);
    endtask

    function automatic logic [9:0] pick_addr();
        int unsigned k = $urandom % 8;
        if (k < 2) return 10'h3FE;
        if (k < 4) return 10'h3FF;
        if (k < 7) return 10'($urandom % 8);
        return 10'($urandom);
    endfunction

    task automatic rand_port(bit left);
        bit ce = ($urandom % 6) == 0;
        bit oe = ($urandom % 3) == 0;
        bit we = ($urandom % 2) == 0;
        bit ih = ($urandom % 5) == 0;
        if (left) lport(ce, oe, we, pick_addr(), 8'($urandom), ih);
        else      rport(ce, oe, we, pick_addr(), 8'($urandom), ih);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        // R11: reset state
        cur_tag = "R11";
        repeat (3) tick();
        chk("l_irq_n", 32'(l_irq_n), 1); chk("r_irq_n", 32'(r_irq_n), 1);
        chk("l_rvalid", 32'(l_rvalid), 0); chk("r_rdata", 32'(r_rdata), 0);
        rst_n = 1'b1;

        // R1: fill the whole array from the left, read back from the right
        cur_tag = "R1";
        for (int a = 0; a < 1024; a++) begin
            lport(0, 1, 0, 10'(a), seedval(a), 0);
            tick();
        end
        idle();
        rport(0, 0, 1, 10'd700, 8'h0, 0); tick();
        chk("r_rdata", 32'(r_rdata), 32'(seedval(700)));
        rport(0, 0, 1, 10'd3, 8'h0, 0); tick();
        chk("r_rdata", 32'(r_rdata), 32'(seedval(3)));

        // R7 and R12: left posts to right mailbox, right collects
        cur_tag = "R7";
        idle(); lport(0, 1, 0, 10'h3FF, 8'hA5, 0); tick();
        chk("r_irq_n", 32'(r_irq_n), 0);
        idle(); rport(0, 0, 1, 10'h3FF, 8'h0, 0); tick();
        cur_tag = "R12";
        chk("r_rdata", 32'(r_rdata), 32'hA5);
        cur_tag = "R7";
        chk("r_irq_n", 32'(r_irq_n), 1);

        // R5: right posts to left mailbox
        cur_tag = "R5";
        idle(); rport(0, 1, 0, 10'h3FE, 8'h3C, 0); tick();
        chk("l_irq_n", 32'(l_irq_n), 0);
        // R6: clear by a left write with output enable low
        cur_tag = "R6";
        idle(); lport(0, 0, 0, 10'h3FE, 8'h77, 0); tick();
        chk("l_irq_n", 32'(l_irq_n), 1);
        cur_tag = "R12";
        idle(); lport(0, 0, 1, 10'h3FE, 8'h0, 0); tick();
        chk("l_rdata", 32'(l_rdata), 32'h77);

        // R4: idle ports do nothing
        cur_tag = "R4";
        idle(); rport(0, 1, 0, 10'h3FE, 8'h77, 0); tick();
        idle(); lport(1, 0, 1, 10'h3FE, 8'h0, 0); rport(1, 0, 0, 10'd5, 8'hFF, 0); tick();
        chk("l_irq_n", 32'(l_irq_n), 0); chk("l_rvalid", 32'(l_rvalid), 0);
        idle(); rport(0, 0, 1, 10'd5, 8'h0, 0); tick();
        chk("r_rdata", 32'(r_rdata), 32'h26);

        // R8: inhibit does not block a clear, but blocks store and set
        cur_tag = "R8";
        idle(); lport(0, 0, 1, 10'h3FE, 8'h0, 1); tick();
        chk("l_irq_n", 32'(l_irq_n), 1);
        idle(); rport(0, 1, 0, 10'h3FE, 8'h11, 1); tick();
        chk("l_irq_n", 32'(l_irq_n), 1);
        idle(); lport(0, 0, 1, 10'h3FE, 8'h0, 0); tick();
        chk("l_rdata", 32'(l_rdata), 32'h77);

        // R9: set and clear at the same edge, set wins
        cur_tag = "R9";
        idle(); rport(0, 1, 0, 10'h3FE, 8'h5A, 0); lport(0, 0, 1, 10'h3FE, 8'h0, 0); tick();
        chk("l_irq_n", 32'(l_irq_n), 0);
        cur_tag = "R3";
        chk("l_rdata", 32'(l_rdata), 32'h77);

        // R3: read old data while the other port writes the same byte
        idle(); lport(0, 1, 0, 10'h020, 8'hAA, 0); rport(0, 0, 1, 10'h020, 8'h0, 0); tick();
        chk("r_rdata", 32'(r_rdata), 32'hE3);

        // R10: equal-address writes, left stored
        cur_tag = "R10";
        idle(); lport(0, 1, 0, 10'h010, 8'hC1, 0); rport(0, 1, 0, 10'h010, 8'h2D, 0); tick();
        idle(); rport(0, 0, 1, 10'h010, 8'h0, 0); tick();
        chk("r_rdata", 32'(r_rdata), 32'hC1);

        // R2: random traffic against the model
        cur_tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            rand_port(1'b1);
            rand_port(1'b0);
            tick();
        end

        // R11: reset with both flags pending keeps memory
        cur_tag = "R11";
        idle(); lport(0, 1, 0, 10'h3FF, 8'h01, 0); rport(0, 1, 0, 10'h3FE, 8'h02, 0); tick();
        idle(); lport(0, 1, 0, 10'h010, 8'h9B, 0); tick();
        idle(); rst_n = 1'b0; tick(); tick();
        chk("l_irq_n", 32'(l_irq_n), 1); chk("r_irq_n", 32'(r_irq_n), 1);
        rst_n = 1'b1;
        lport(0, 0, 1, 10'h010, 8'h0, 0); rport(0, 0, 1, 10'h3FE, 8'h0, 0); tick();
        chk("l_rdata", 32'(l_rdata), 32'h9B);
        chk("r_rdata", 32'(r_rdata), 32'h02);
        idle(); tick();

        finish_run();
    end

endmodule